// File: doc/BRIEF.md
# Password Verify and Acknowledge-Poll Responder

This block sits behind a serial byte layer and gates access to a protected data phase. When an operation that needs a password begins, the block takes the next eight bytes as the password. It compares them, one byte at a time, with one of three stored 64-bit passwords: read, write or configuration. Every password byte is acknowledged, whether it matches or not, so the byte stream itself does not reveal a wrong guess.

After the eighth byte the block always enters a busy window of fixed length. This window models a nonvolatile write cycle. During and after the window, the host polls with a dedicated command byte. While the window runs, every poll is refused. After the window, the poll is accepted only if the whole password matched. A host therefore cannot tell a wrong password from a busy device until the window has run out. An accepted poll raises the grant flag, which opens the data phase. Operations that need no password are granted at once. A stop condition ends the transaction from any state.

Top module: `pwd_poll_gate`

## Requirements
- R1: After reset, `ack_valid`, `busy` and `grant` are all 0.
- R2: In the password phase, each of the eight bytes gives `ack_valid`=1 with `ack`=1 on the cycle after `byte_valid`, whatever the byte value.
- R3: The cycle after the eighth password byte, `busy` rises and stays high for exactly `BUSY_CYCLES` cycles.
- R4: While `busy` is high, a poll byte 8'hC0 gives `ack_valid`=1 with `ack`=0, and the transaction continues.
- R5: After the busy window, if all eight bytes matched, a poll byte 8'hC0 gives `ack`=1, and `grant` rises on the same cycle.
- R6: After the busy window, if any byte differed, every poll byte 8'hC0 gives `ack`=0 and `grant` stays 0.
- R7: A poll byte other than 8'hC0, during or after the busy window, gives `ack`=0 and returns the block to idle. In idle, bytes produce no `ack_valid`.
- R8: An `op_start` with `need_pwd`=0 raises `grant` on the next cycle without any acknowledge.
- R9: A `stop_evt` pulse clears `grant` and `busy` on the next cycle and returns the block to idle. It takes priority over a byte in the same cycle.
- R10: `pwd_sel` is sampled at `op_start`: 0 selects `rd_pwd`, 1 selects `wr_pwd`, 2 or 3 selects `cfg_pwd`. Password byte k (k=0 first) is compared with bits [8k+7:8k]. A mismatch in any single byte, including the last, denies the poll.
- R11: The mismatch state is cleared at each new `op_start`, so a failed attempt does not affect the next transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Pulse: an operation begins (used only in idle) |
| need_pwd | input | 1 | The operation requires a password |
| pwd_sel | input | 2 | Password select: 0 read, 1 write, 2/3 configuration |
| byte_valid | input | 1 | Pulse: a received byte is on `byte_data` |
| byte_data | input | 8 | Received byte |
| stop_evt | input | 1 | Pulse: stop condition seen on the bus |
| rd_pwd | input | 64 | Stored read password |
| wr_pwd | input | 64 | Stored write password |
| cfg_pwd | input | 64 | Stored configuration password |
| ack_valid | output | 1 | The acknowledge decision for the last byte is on `ack` |
| ack | output | 1 | 1 = ACK, 0 = NACK |
| busy | output | 1 | The busy window is running |
| grant | output | 1 | The data phase is allowed |

## Verification
The hardest case to reach from the ports is a password that differs only in its last byte. Such an attempt is indistinguishable from a correct one through all eight acknowledges and the whole busy window; the difference shows only in the first poll after the window ends. The stimulus builds this attempt on the configuration password, polls repeatedly to confirm that the refusal persists, and then sends the correct password straight away. That second attempt shows the stale mismatch is gone. A second case uses a correct write password while the read selector is active, which shows the selection is honoured rather than any stored value being accepted.

// File: rtl/pwd_poll_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the password / poll gate.
package pwd_poll_pkg;
    localparam int          PWD_BYTES = 8;
    localparam logic [7:0]  POLL_CODE = 8'hC0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWD,
        ST_BUSY,
        ST_WAIT,
        ST_GRANT
    } gate_state_t;
endpackage

// File: rtl/pwd_byte_cmp.sv
`timescale 1ns/1ps
// Byte-serial password comparator.
// Does: steps a byte index through the reference password, low byte first,
//       and keeps a sticky mismatch flag across the sequence.
// Assumes: clear and load are never high together; the caller stops
//          loading after the last byte.
module pwd_byte_cmp #(
    parameter int NBYTES = 8,
    localparam int IW = $clog2(NBYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 load,
    input  logic [7:0]           byte_in,
    input  logic [NBYTES*8-1:0]  ref_pwd,
    output logic                 last_byte,
    output logic                 mismatch
);
    logic [IW-1:0] idx;
    logic [7:0]    ref_byte [NBYTES];

    // Slice the reference password into bytes.
    for (genvar k = 0; k < NBYTES; k++) begin : g_slice
        assign ref_byte[k] = ref_pwd[8*k +: 8];
    end

    assign last_byte = (idx == IW'(NBYTES - 1));

    // Advance the byte index and accumulate the mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx      <= '0;
            mismatch <= 1'b0;
        end else if (load) begin
            idx      <= last_byte ? '0 : idx + 1'b1;
            mismatch <= mismatch | (byte_in != ref_byte[idx]);
        end
    end

    p_mismatch_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch && !clear) |=> mismatch);
endmodule

// File: rtl/pwd_busy_timer.sv
`timescale 1ns/1ps
// Busy-window countdown.
// Does: once started, stays running for exactly CYCLES cycles and flags
//       its final cycle.
// Assumes: CYCLES >= 1; abort wins over start.
module pwd_busy_timer #(
    parameter int CYCLES = 2000000,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic running,
    output logic expired
);
    logic [CW-1:0] cnt;

    assign expired = running && (cnt == '0);

    // Load, count down and stop the window.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (start) begin
            cnt     <= CW'(CYCLES - 1);
            running <= 1'b1;
        end else if (running) begin
            if (cnt == '0) running <= 1'b0;
            else           cnt     <= cnt - 1'b1;
        end
    end

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt < CW'(CYCLES)));
endmodule

// File: rtl/pwd_poll_gate.sv
`timescale 1ns/1ps
// Password verify and acknowledge-poll responder (top).
// Does: checks an 8-byte password against the selected stored password,
//       runs a fixed busy window, answers poll bytes and grants the data phase.
// Assumes: the byte layer gives one-cycle byte_valid / stop_evt pulses and
//          handles the ACK bit timing on the wire.
module pwd_poll_gate
    import pwd_poll_pkg::*;
#(
    parameter int BUSY_CYCLES = 2000000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_start,
    input  logic        need_pwd,
    input  logic [1:0]  pwd_sel,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    input  logic        stop_evt,
    input  logic [63:0] rd_pwd,
    input  logic [63:0] wr_pwd,
    input  logic [63:0] cfg_pwd,
    output logic        ack_valid,
    output logic        ack,
    output logic        busy,
    output logic        grant
);
    gate_state_t st, st_nxt;
    logic [1:0]  sel_q;
    logic [63:0] ref_pwd;
    logic        cmp_clear, cmp_load, last_byte, mismatch;
    logic        tmr_start, tmr_abort, tmr_run, tmr_expired;
    logic        ackv_nxt, ack_nxt;

    // Pick the stored password chosen at transaction start.
    always_comb begin
        case (sel_q)
            2'd0:    ref_pwd = rd_pwd;
            2'd1:    ref_pwd = wr_pwd;
            default: ref_pwd = cfg_pwd;
        endcase
    end

    assign cmp_clear = (st == ST_IDLE) && op_start && !stop_evt;
    assign cmp_load  = (st == ST_PWD) && byte_valid && !stop_evt;
    assign tmr_start = cmp_load && last_byte;
    assign tmr_abort = (st_nxt == ST_IDLE);

    pwd_byte_cmp #(.NBYTES(PWD_BYTES)) u_cmp (
        .clk(clk), .rst_n(rst_n), .clear(cmp_clear), .load(cmp_load),
        .byte_in(byte_data), .ref_pwd(ref_pwd),
        .last_byte(last_byte), .mismatch(mismatch)
    );

    pwd_busy_timer #(.CYCLES(BUSY_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .abort(tmr_abort),
        .running(tmr_run), .expired(tmr_expired)
    );

    // Next state and acknowledge decision for the current byte.
    always_comb begin
        st_nxt   = st;
        ackv_nxt = 1'b0;
        ack_nxt  = 1'b0;
        if (stop_evt) begin
            st_nxt = ST_IDLE;
        end else begin
            case (st)
                ST_IDLE: if (op_start) st_nxt = need_pwd ? ST_PWD : ST_GRANT;
                ST_PWD: if (byte_valid) begin
                    ackv_nxt = 1'b1;
                    ack_nxt  = 1'b1;
                    if (last_byte) st_nxt = ST_BUSY;
                end
                ST_BUSY: begin
                    if (byte_valid) ackv_nxt = 1'b1;
                    if (byte_valid && byte_data != POLL_CODE) st_nxt = ST_IDLE;
                    else if (tmr_expired)                      st_nxt = ST_WAIT;
                end
                ST_WAIT: if (byte_valid) begin
                    ackv_nxt = 1'b1;
                    if (byte_data != POLL_CODE) st_nxt = ST_IDLE;
                    else if (!mismatch) begin
                        ack_nxt = 1'b1;
                        st_nxt  = ST_GRANT;
                    end
                end
                default: ;
            endcase
        end
    end

    // State, select latch and registered acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            sel_q     <= 2'd0;
            ack_valid <= 1'b0;
            ack       <= 1'b0;
        end else begin
            st        <= st_nxt;
            ack_valid <= ackv_nxt;
            ack       <= ack_nxt;
            if (cmp_clear) sel_q <= pwd_sel;
        end
    end

    assign busy  = (st == ST_BUSY);
    assign grant = (st == ST_GRANT);

    p_ack_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(byte_valid));
    p_busy_nack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && byte_valid && !stop_evt) |=> (ack_valid && !ack));
    p_grant_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant) |-> ((ack_valid && ack) || $past(op_start && !need_pwd)));
    p_idle_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && byte_valid) |=> !ack_valid);
    p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (!grant && !busy));
    p_busy_matches_timer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> tmr_run);
endmodule

// File: tb/pwd_poll_gate_bench.sv
`timescale 1ns/1ps
module pwd_poll_gate_bench;
    localparam int N = 16;
    localparam logic [63:0] RDP  = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] WRP  = 64'hFEDC_BA98_7654_3210;
    localparam logic [63:0] CFGP = 64'h5A5A_1234_C3C3_9876;

    logic clk = 1'b0, rst_n = 1'b0;
    logic op_start = 0, need_pwd = 0, byte_valid = 0, stop_evt = 0;
    logic [1:0] pwd_sel = 0;
    logic [7:0] byte_data = 0;
    logic ack_valid, ack, busy, grant;
    int checks = 0, failures = 0;
    logic [1:0] expq [$];   // {expect ack_valid, expected ack}

    always #2.5 clk = ~clk;

    pwd_poll_gate #(.BUSY_CYCLES(N)) u_pwd_poll_gate (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .need_pwd(need_pwd),
        .pwd_sel(pwd_sel), .byte_valid(byte_valid), .byte_data(byte_data),
        .stop_evt(stop_evt), .rd_pwd(RDP), .wr_pwd(WRP), .cfg_pwd(CFGP),
        .ack_valid(ack_valid), .ack(ack), .busy(busy), .grant(grant));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pop the expectation for each byte just after its edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && byte_valid) begin
            logic [1:0] e;
            e = (expq.size() > 0) ? expq.pop_front() : 2'b00;
            check(ack_valid == e[1], "R2/R7 ack_valid", int'(ack_valid), int'(e[1]));
            if (e[1]) check(ack == e[0], "R2/R4/R5/R6 ack", int'(ack), int'(e[0]));
        end else if (rst_n && ack_valid) begin
            check(1'b0, "R2 spurious ack_valid", 1, 0);
        end
    end

    task automatic send(input logic [7:0] b, input logic [1:0] e);
        @(negedge clk);
        byte_valid = 1'b1; byte_data = b; expq.push_back(e);
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic begin_op(input logic [1:0] sel, input logic need);
        @(negedge clk);
        op_start = 1'b1; pwd_sel = sel; need_pwd = need;
        @(negedge clk);
        op_start = 1'b0;
    endtask

    task automatic send_pwd(input logic [63:0] p);
        for (int k = 0; k < 8; k++) send(p[8*k +: 8], 2'b11);
    endtask

    task automatic stop_now();
        @(negedge clk); stop_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0;
        check(!grant && !busy, "R9 stop clears", int'({grant, busy}), 0);
    endtask

    task automatic wait_idle_busy();
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        check(!ack_valid && !busy && !grant, "R1 reset", int'({ack_valid, busy, grant}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ack_valid && !busy && !grant, "R1 after reset", int'({ack_valid, busy, grant}), 0);

        // Idle bytes are ignored (R7)
        send(8'hC0, 2'b00);

        // Correct read password, poll during busy, then grant (R2 R4 R5)
        begin_op(2'd0, 1'b1);
        send_pwd(RDP);
        check(busy, "R3 busy rises", int'(busy), 1);
        send(8'hC0, 2'b10);                       // R4 NACK while busy
        check(busy, "R4 still busy", int'(busy), 1);
        wait_idle_busy();
        send(8'hC0, 2'b11);                       // R5 ACK
        check(grant, "R5 grant", int'(grant), 1);
        send(8'h42, 2'b00);                       // data phase: no ack from block
        stop_now();

        // Write password: busy length exactly N (R3)
        begin_op(2'd1, 1'b1);
        send_pwd(WRP);
        cnt = 0;
        while (busy) begin cnt++; @(negedge clk); end
        check(cnt == N, "R3 busy length", cnt, N);
        send(8'hC0, 2'b11);
        check(grant, "R5 grant write", int'(grant), 1);
        stop_now();

        // Config password wrong in last byte only (R10 R6)
        begin_op(2'd2, 1'b1);
        send_pwd(CFGP ^ 64'h0100_0000_0000_0000);
        wait_idle_busy();
        send(8'hC0, 2'b10);
        send(8'hC0, 2'b10);
        check(!grant, "R6 no grant", int'(grant), 0);
        stop_now();

        // Correct config password right after: mismatch cleared (R11)
        begin_op(2'd3, 1'b1);
        send_pwd(CFGP);
        wait_idle_busy();
        send(8'hC0, 2'b11);
        check(grant, "R11 fresh attempt granted", int'(grant), 1);
        stop_now();

        // Read selected but write password supplied (R10)
        begin_op(2'd0, 1'b1);
        send_pwd(WRP);
        wait_idle_busy();
        send(8'hC0, 2'b10);
        check(!grant, "R10 wrong selection denied", int'(grant), 0);
        stop_now();

        // Wrong poll code after the window aborts (R7)
        begin_op(2'd0, 1'b1);
        send_pwd(RDP);
        wait_idle_busy();
        send(8'hA5, 2'b10);
        send(8'hC0, 2'b00);
        check(!grant, "R7 aborted", int'(grant), 0);

        // Wrong poll code during the window aborts (R7)
        begin_op(2'd1, 1'b1);
        send_pwd(WRP);
        send(8'h3C, 2'b10);
        check(!busy, "R7 busy aborted", int'(busy), 0);
        send(8'hC0, 2'b00);

        // No password needed (R8)
        begin_op(2'd0, 1'b0);
        check(grant, "R8 immediate grant", int'(grant), 1);
        stop_now();

        // Stop in the middle of the password (R9)
        begin_op(2'd2, 1'b1);
        send(CFGP[7:0], 2'b11);
        send(CFGP[15:8], 2'b11);
        stop_now();
        send(8'h11, 2'b00);
        check(!busy, "R9 no busy after stop", int'(busy), 0);

        repeat (2) @(negedge clk);
        check(expq.size() == 0, "scoreboard drained", expq.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule